// File: doc/BRIEF.md
# Unlock-Gated Hidden Register Banks

This block is a slave-side register file reached through a simple synchronous management port. Software sees only three registers: a control register, a write-data register and a read-data register. Behind them sit four hidden banks of thirty-two 16-bit registers. These banks can be reached only indirectly, by command words written to the control register.

The hidden banks stay locked until a fixed four-step unlock sequence has been written to the control register. Once the banks are open, a write command stores the write-data register into one bank entry. A read command copies one bank entry into the read-data register, which software then reads over the management port. Writing zero to the control register locks the banks again.

Management-side register addresses are 0 for control, 1 for write-data, 2 for read-data and 3 for a reserved address. The control word carries these fields: bit 15 is the read command, bit 14 the write command, bits 12:11 the bank, bit 10 the test-mode enable, bits 9:5 the read address and bits 4:0 the write address.

Top module: `hidden_bank_port`

## Requirements
- R1: After a synchronous reset, the control, write-data and read-data registers all read 0. Every hidden bank entry also reads back as 0 once the banks have been opened.
- R2: A read with reg_rd high presents data on reg_rdata in the following cycle, and reg_rdata holds that value until the next read. Address 0 returns the last control word written and address 1 returns the write-data register. Address 2 returns the read-data register and address 3 returns 0. Writes to addresses 2 and 3 have no effect.
- R3: The banks open only after four consecutive control writes of 0x0000, 0x0400, 0x0000 and 0x0400. Writes to other addresses between these steps neither count as steps nor break the sequence.
- R4: A control write that does not match the next expected step returns the sequence to its start. If that mismatching word is 0x0000, it counts as the first step of a new sequence.
- R5: While the banks are open, a control word with bit 14 set writes the write-data register into the entry selected by bank bits 12:11 and write address bits 4:0.
- R6: While the banks are open, a control word with bit 15 set and bit 14 clear loads the read-data register from the entry selected by bank bits 12:11 and read address bits 9:5.
- R7: A control word with both bit 15 and bit 14 set performs only the write, and the read-data register keeps its value.
- R8: Writing 0x0000 to the control register while the banks are open locks them. Later commands are then ignored until the full unlock sequence is written again.
- R9: A read or write command issued while the banks are locked changes neither the bank contents nor the read-data register.
- R10: The same entry address in different banks refers to distinct storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Management register address (0 control, 1 write-data, 2 read-data, 3 reserved) |
| reg_wr | input | 1 | Management write strobe |
| reg_wdata | input | 16 | Management write data |
| reg_rd | input | 1 | Management read strobe |
| reg_rdata | output | 16 | Registered read data, valid the cycle after reg_rd |

## Verification
The only window on the hidden state is the read-data register, seen through address 2. An error in the unlock sequencer therefore shows up as a command that takes effect when it should not, or that is dropped when it should take effect. Such an error becomes visible two cycles after a later read command, once the resulting read-data value is read out. A corrupted bank entry stays hidden until that entry is read back. For this reason the stimulus reads back every entry it writes, and it re-reads the read-data register after each command issued while the banks are locked. A behavioural model is compared against reg_rdata on every clock, so any divergence is reported in the cycle it reaches the port.

// File: rtl/hbank_pkg.sv
package hbank_pkg;
  localparam int CTRL_W  = 16;
  localparam int RD_BIT  = 15;
  localparam int WR_BIT  = 14;
  localparam int BANK_LO = 11;
  localparam int TM_BIT  = 10;
  localparam int RA_LO   = 5;
  localparam int WA_LO   = 0;

  localparam logic [CTRL_W-1:0] TM_WORD = CTRL_W'(1) << TM_BIT;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_WDATA = 2'd1;
  localparam logic [1:0] A_RDATA = 2'd2;

  typedef enum logic [2:0] {
    ST_WAIT_Z0,
    ST_WAIT_T0,
    ST_WAIT_Z1,
    ST_WAIT_T1,
    ST_OPEN
  } unlock_t;
endpackage

// File: rtl/hbank_unlock.sv
module hbank_unlock
  import hbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              open
);
  unlock_t st, nxt;
  logic    is_zero, is_tm;

  assign is_zero = (ctrl_word == '0);
  assign is_tm   = (ctrl_word == TM_WORD);

  always_comb begin
    nxt = st;
    if (ctrl_wr) begin
      unique case (st)
        ST_WAIT_Z0: nxt = is_zero ? ST_WAIT_T0 : ST_WAIT_Z0;
        ST_WAIT_T0: nxt = is_tm ? ST_WAIT_Z1 : (is_zero ? ST_WAIT_T0 : ST_WAIT_Z0);
        ST_WAIT_Z1: nxt = is_zero ? ST_WAIT_T1 : ST_WAIT_Z0;
        ST_WAIT_T1: nxt = is_tm ? ST_OPEN : (is_zero ? ST_WAIT_T0 : ST_WAIT_Z0);
        ST_OPEN:    nxt = is_zero ? ST_WAIT_T0 : ST_OPEN;
        default:    nxt = ST_WAIT_Z0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_WAIT_Z0;
    else     st <= nxt;
  end

  assign open = (st == ST_OPEN);

  // R3
  open_needs_tm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(open) |-> ($past(ctrl_wr) && $past(ctrl_word) == TM_WORD));

  // R8
  close_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (open && ctrl_wr && is_zero) |=> !open);

  // R4
  bad_word_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!open && ctrl_wr && !is_zero && !is_tm) |=> (st == ST_WAIT_Z0));
endmodule

// File: rtl/hbank_store.sv
module hbank_store #(
  parameter int DATA_W = 16,
  parameter int BANKS  = 4,
  parameter int DEPTH  = 32,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int IDX_W   = BANK_W + ADDR_W,
  localparam int ENTRIES = BANKS * DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_value
);
  logic [DATA_W-1:0]  mem [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [DATA_W-1:0]  mem_q;
  logic               vld_q;
  logic [IDX_W-1:0]   widx, ridx;

  assign widx = {wr_bank, wr_addr};
  assign ridx = {rd_bank, rd_addr};

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[widx] <= wr_data;
    if (rd_en) mem_q <= mem[ridx];
  end

  // per-entry written flags give the zero-after-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (wr_en) vld[widx] <= 1'b1;
      if (rd_en) vld_q <= vld[ridx];
    end
  end

  assign rd_value = vld_q ? mem_q : '0;

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_value));
endmodule

// File: rtl/hidden_bank_port.sv
module hidden_bank_port
  import hbank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BANKS  = 4,
  parameter int DEPTH  = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [DATA_W-1:0] ctrl_q, wdata_q, rd_value;
  logic              ctrl_wr, open, cmd_wr, cmd_rd;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] waddr, raddr;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign bank    = reg_wdata[BANK_LO +: BANK_W];
  assign waddr   = reg_wdata[WA_LO +: ADDR_W];
  assign raddr   = reg_wdata[RA_LO +: ADDR_W];
  assign cmd_wr  = ctrl_wr && open && reg_wdata[WR_BIT];
  assign cmd_rd  = ctrl_wr && open && reg_wdata[RD_BIT] && !reg_wdata[WR_BIT];

  hbank_unlock u_unlock (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_word (reg_wdata),
    .open      (open)
  );

  hbank_store #(.DATA_W(DATA_W), .BANKS(BANKS), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cmd_wr),
    .wr_bank  (bank),
    .wr_addr  (waddr),
    .wr_data  (wdata_q),
    .rd_en    (cmd_rd),
    .rd_bank  (bank),
    .rd_addr  (raddr),
    .rd_value (rd_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      wdata_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= reg_wdata;
      if (reg_wr && reg_addr == A_WDATA) wdata_q <= reg_wdata;
      if (reg_rd) begin
        unique case (reg_addr)
          A_CTRL:  reg_rdata <= ctrl_q;
          A_WDATA: reg_rdata <= wdata_q;
          A_RDATA: reg_rdata <= rd_value;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

  // R9
  locked_cmd_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !open) |=> $stable(rd_value));

  // R7
  wr_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && open && reg_wdata[WR_BIT] && reg_wdata[RD_BIT]) |=> $stable(rd_value));
endmodule

// File: tb/tb_hidden_bank_port.sv
module tb_hidden_bank_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int    m_mem [4][32];
  int    m_ctrl, m_wdata, m_rdreg, m_out, m_step;
  int    total = 0, bad = 0;
  bit    done = 0;
  string tag = "R1 reset";

  hidden_bank_port dut (
    .clk(clk), .rst(rst), .reg_addr(addr), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rd(rd), .reg_rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      foreach (m_mem[b, a]) m_mem[b][a] = 0;
      m_ctrl = 0; m_wdata = 0; m_rdreg = 0; m_out = 0; m_step = 0;
    end else begin
      if (rd) begin
        case (addr)
          2'd0: m_out = m_ctrl;
          2'd1: m_out = m_wdata;
          2'd2: m_out = m_rdreg;
          default: m_out = 0;
        endcase
      end
      if (wr && addr == 2'd1) m_wdata = wdata;
      if (wr && addr == 2'd0) begin
        m_ctrl = wdata;
        if (m_step == 4) begin
          if (wdata == 0) m_step = 1;
          else if (wdata[14]) m_mem[(wdata >> 11) & 3][wdata & 31] = m_wdata;
          else if (wdata[15]) m_rdreg = m_mem[(wdata >> 11) & 3][(wdata >> 5) & 31];
        end else begin
          if (int'(wdata) == (((m_step % 2) == 0) ? 0 : 'h400)) m_step = m_step + 1;
          else m_step = (wdata == 0) ? 1 : 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (rdata !== 16'(m_out)) begin
        bad++;
        $display("FAIL %s: reg_rdata got %h expected %h", tag, rdata, 16'(m_out));
      end
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(posedge clk);
  endtask

  task automatic rd_reg(input logic [1:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    @(posedge clk);
  endtask

  task automatic unlock();
    wr_reg(2'd0, 16'h0000); wr_reg(2'd0, 16'h0400);
    wr_reg(2'd0, 16'h0000); wr_reg(2'd0, 16'h0400);
  endtask

  function automatic logic [15:0] cmd(input bit r, input bit w, input int b, input int ra, input int wa);
    return (16'(r) << 15) | (16'(w) << 14) | 16'((b & 3) << 11) | 16'((ra & 31) << 5) | 16'(wa & 31);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk);
    tag = "R1 reset registers";
    rd_reg(2'd0); rd_reg(2'd1); rd_reg(2'd2);

    tag = "R2 register map";
    wr_reg(2'd1, 16'hBEEF); rd_reg(2'd1);
    wr_reg(2'd0, 16'h1357); rd_reg(2'd0);
    rd_reg(2'd3);
    wr_reg(2'd2, 16'hFFFF); wr_reg(2'd3, 16'hAAAA); rd_reg(2'd2); rd_reg(2'd3);

    tag = "R9 locked commands";
    wr_reg(2'd0, cmd(0, 1, 0, 0, 3));
    wr_reg(2'd0, cmd(1, 0, 0, 3, 0)); rd_reg(2'd2);

    tag = "R1 bank cleared";
    unlock();
    wr_reg(2'd0, cmd(1, 0, 2, 7, 0)); rd_reg(2'd2);

    tag = "R5 R6 R10 bank access";
    wr_reg(2'd1, 16'h1234); wr_reg(2'd0, cmd(0, 1, 0, 0, 5));
    wr_reg(2'd1, 16'hABCD); wr_reg(2'd0, cmd(0, 1, 1, 0, 5));
    wr_reg(2'd1, 16'h0F0F); wr_reg(2'd0, cmd(0, 1, 3, 0, 31));
    wr_reg(2'd0, cmd(1, 0, 0, 5, 0)); rd_reg(2'd2);
    wr_reg(2'd0, cmd(1, 0, 1, 5, 0)); rd_reg(2'd2);
    wr_reg(2'd0, cmd(1, 0, 3, 31, 0)); rd_reg(2'd2);
    wr_reg(2'd0, cmd(1, 0, 2, 5, 0)); rd_reg(2'd2);

    tag = "R7 write priority";
    wr_reg(2'd0, cmd(1, 0, 0, 5, 0));
    wr_reg(2'd1, 16'h5A5A); wr_reg(2'd0, cmd(1, 1, 1, 5, 9)); rd_reg(2'd2);
    wr_reg(2'd0, cmd(1, 0, 1, 9, 0)); rd_reg(2'd2);

    tag = "R8 close";
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd1, 16'h7777); wr_reg(2'd0, cmd(0, 1, 0, 0, 5));
    wr_reg(2'd0, cmd(1, 0, 3, 31, 0)); rd_reg(2'd2);
    unlock();
    wr_reg(2'd0, cmd(1, 0, 0, 5, 0)); rd_reg(2'd2);

    tag = "R4 broken sequence";
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd0, 16'h0000); wr_reg(2'd0, 16'h0400); wr_reg(2'd0, 16'h0401); wr_reg(2'd0, 16'h0400);
    wr_reg(2'd0, cmd(1, 0, 3, 31, 0)); rd_reg(2'd2);
    wr_reg(2'd0, 16'h0000); wr_reg(2'd0, 16'h0400); wr_reg(2'd0, 16'h0000); wr_reg(2'd0, 16'h0000);
    wr_reg(2'd0, 16'h0400); wr_reg(2'd0, 16'h0000); wr_reg(2'd0, 16'h0400);
    wr_reg(2'd0, cmd(1, 0, 3, 31, 0)); rd_reg(2'd2);

    tag = "R3 interleaved unlock";
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd0, 16'h0000); wr_reg(2'd1, 16'h2222); wr_reg(2'd0, 16'h0400);
    wr_reg(2'd0, 16'h0000); wr_reg(2'd1, 16'h3333); wr_reg(2'd0, 16'h0400);
    wr_reg(2'd0, cmd(0, 1, 2, 0, 1)); wr_reg(2'd0, cmd(1, 0, 2, 1, 0)); rd_reg(2'd2);
    wr_reg(2'd0, 16'h0000); wr_reg(2'd0, 16'h0400); wr_reg(2'd0, 16'h0000);
    wr_reg(2'd0, cmd(1, 0, 1, 5, 0)); rd_reg(2'd2);

    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule